// File: doc/BRIEF.md
# Aliased Scalar/Vector Register File

This block stores 32 architectural registers that three register classes share. Each entry is up to 256 bits wide. The same index names the same physical entry in every class, so the classes alias one another. A 64-bit scalar floating-point access uses the bottom quarter of the entry, a 128-bit short-vector access uses the bottom half, and a 256-bit long-vector access uses all of it.

Each cycle the block takes one write and two independent reads. A two-bit width tag on each access picks the view. A narrow write merges into the entry and leaves the bits above its view untouched. Reads are combinational from the stored state. A write becomes visible on the cycle after its clock edge.

A build-time switch removes the long-vector view. In that build each entry holds only 128 bits.

Top module: `alias_vrf`

## Requirements
- R1: There are 32 entries indexed 0 to 31, and index n in every view refers to the same physical entry, so a value written through one view can be read through another.
- R2: Width tag 2'b10 selects the 256-bit long-vector view: a write replaces the full entry and a read returns all 256 bits.
- R3: Width tag 2'b01 selects the 128-bit short-vector view, which covers bits 127:0 of the entry.
- R4: Width tag 2'b00 selects the 64-bit scalar view, which covers bits 63:0 of the entry.
- R5: A scalar or short-vector write changes only the bits its view covers; all higher bits of that entry keep their previous value.
- R6: A write with width tag 2'b11, or with the write enable low, changes no entry.
- R7: A read of the index written in the same cycle returns the old value; the new value is returned from the next cycle on.
- R8: While reset is asserted every entry is cleared to zero.
- R9: A read returns its view's bits zero-extended to 256 bits; a read with width tag 2'b11 returns all zeros.
- R10: The two read ports are independent: each has its own index and width tag.
- R11: With the long-vector view disabled, each entry holds 128 bits: a 2'b10 write stores bits 127:0 only, and a 2'b10 read returns those bits with bits 255:128 zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset, clears all entries |
| wrEn | input | 1 | Write enable |
| wrIdx | input | 5 | Entry to write |
| wrWidth | input | 2 | Write view tag: 00 scalar, 01 short, 10 long, 11 none |
| wrData | input | 256 | Write data; the view uses its low bits |
| rdIdxA | input | 5 | Read port A entry |
| rdWidthA | input | 2 | Read port A view tag (same encoding) |
| rdDataA | output | 256 | Read port A data, zero-extended |
| rdIdxB | input | 5 | Read port B entry |
| rdWidthB | input | 2 | Read port B view tag (same encoding) |
| rdDataB | output | 256 | Read port B data, zero-extended |

## Verification
A lane strobe that fires wrongly shows up on the cycle after the write. It appears as upper bits that were overwritten, or left stale, when the entry is read back through a wider view. The bench therefore reads each written entry back through the long view and through a different view than the one used to write it. The same-cycle read catches a bypass that should not exist, because it exposes the new data one cycle early. A bad view multiplexer shows at once as nonzero bits above the requested width.

// File: rtl/alias_vrf_pkg.sv
package alias_vrf_pkg;
  localparam int FULL_W   = 256;
  localparam int SHORT_W  = 128;
  localparam int SCALAR_W = 64;

  typedef enum logic [1:0] {
    VIEW_SCALAR = 2'b00,
    VIEW_SHORT  = 2'b01,
    VIEW_LONG   = 2'b10,
    VIEW_NONE   = 2'b11
  } view_t;

  // lane strobes from control to datapath
  typedef struct packed {
    logic wrLo;   // bits 63:0
    logic wrMid;  // bits 127:64
    logic wrHi;   // bits 255:128
  } laneStrb_t;

  function automatic logic [FULL_W-1:0] viewSel(input logic [FULL_W-1:0] ent, input view_t v);
    logic [FULL_W-1:0] res;
    case (v)
      VIEW_SCALAR: res = {{(FULL_W-SCALAR_W){1'b0}}, ent[SCALAR_W-1:0]};
      VIEW_SHORT:  res = {{(FULL_W-SHORT_W){1'b0}}, ent[SHORT_W-1:0]};
      VIEW_LONG:   res = ent;
      default:     res = '0;
    endcase
    return res;
  endfunction
endpackage

// File: rtl/alias_vrf_ctrl.sv
module alias_vrf_ctrl
  import alias_vrf_pkg::*;
#(
  parameter bit LONG_EN = 1'b1
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      wrEn,
  input  logic [1:0] wrWidth,
  output laneStrb_t strb
);
  always_comb begin
    strb = '0;
    if (wrEn) begin
      case (view_t'(wrWidth))
        VIEW_SCALAR: strb.wrLo = 1'b1;
        VIEW_SHORT: begin
          strb.wrLo  = 1'b1;
          strb.wrMid = 1'b1;
        end
        VIEW_LONG: begin
          strb.wrLo  = 1'b1;
          strb.wrMid = 1'b1;
          strb.wrHi  = LONG_EN;
        end
        default: strb = '0;
      endcase
    end
  end

  // R6
  no_write_tag_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrWidth == 2'b11 || !wrEn) |-> (strb == '0));

  // R2
  lane_nesting_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrHi |-> strb.wrMid) and (strb.wrMid |-> strb.wrLo));
endmodule

// File: rtl/alias_vrf_dp.sv
module alias_vrf_dp
  import alias_vrf_pkg::*;
#(
  parameter int NUM_REGS = 32,
  parameter bit LONG_EN  = 1'b1,
  localparam int IDX_W   = $clog2(NUM_REGS),
  localparam int HI_W    = FULL_W - SHORT_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  laneStrb_t         strb,
  input  logic [IDX_W-1:0]  wrIdx,
  input  logic [FULL_W-1:0] wrData,
  input  logic [IDX_W-1:0]  rdIdxA,
  input  logic [1:0]        rdWidthA,
  output logic [FULL_W-1:0] rdDataA,
  input  logic [IDX_W-1:0]  rdIdxB,
  input  logic [1:0]        rdWidthB,
  output logic [FULL_W-1:0] rdDataB
);
  logic [SHORT_W-1:0] lowMem [NUM_REGS];
  logic [HI_W-1:0]    hiA, hiB;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_REGS; i++) lowMem[i] <= '0;
    end else begin
      if (strb.wrLo)  lowMem[wrIdx][SCALAR_W-1:0]       <= wrData[SCALAR_W-1:0];
      if (strb.wrMid) lowMem[wrIdx][SHORT_W-1:SCALAR_W] <= wrData[SHORT_W-1:SCALAR_W];
    end
  end

  generate
    if (LONG_EN) begin : gHi
      logic [HI_W-1:0] hiMem [NUM_REGS];
      always_ff @(posedge clk) begin
        if (!rstN) begin
          for (int i = 0; i < NUM_REGS; i++) hiMem[i] <= '0;
        end else if (strb.wrHi) begin
          hiMem[wrIdx] <= wrData[FULL_W-1:SHORT_W];
        end
      end
      assign hiA = hiMem[rdIdxA];
      assign hiB = hiMem[rdIdxB];
    end else begin : gNoHi
      assign hiA = '0;
      assign hiB = '0;
    end
  endgenerate

  always_comb begin
    rdDataA = viewSel({hiA, lowMem[rdIdxA]}, view_t'(rdWidthA));
    rdDataB = viewSel({hiB, lowMem[rdIdxB]}, view_t'(rdWidthB));
  end

  // R5
  narrow_keeps_mid_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrLo && !strb.wrMid) |=>
      lowMem[$past(wrIdx)][SHORT_W-1:SCALAR_W] == $past(lowMem[wrIdx][SHORT_W-1:SCALAR_W]));

  // R7
  write_lands_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrLo |=> lowMem[$past(wrIdx)][SCALAR_W-1:0] == $past(wrData[SCALAR_W-1:0]));
endmodule

// File: rtl/alias_vrf.sv
module alias_vrf
  import alias_vrf_pkg::*;
#(
  parameter int NUM_REGS = 32,
  parameter bit LONG_EN  = 1'b1,
  localparam int IDX_W   = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [IDX_W-1:0]  wrIdx,
  input  logic [1:0]        wrWidth,
  input  logic [FULL_W-1:0] wrData,
  input  logic [IDX_W-1:0]  rdIdxA,
  input  logic [1:0]        rdWidthA,
  output logic [FULL_W-1:0] rdDataA,
  input  logic [IDX_W-1:0]  rdIdxB,
  input  logic [1:0]        rdWidthB,
  output logic [FULL_W-1:0] rdDataB
);
  laneStrb_t strb;

  alias_vrf_ctrl #(.LONG_EN(LONG_EN)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrWidth(wrWidth), .strb(strb)
  );

  alias_vrf_dp #(.NUM_REGS(NUM_REGS), .LONG_EN(LONG_EN)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .wrIdx(wrIdx), .wrData(wrData),
    .rdIdxA(rdIdxA), .rdWidthA(rdWidthA), .rdDataA(rdDataA),
    .rdIdxB(rdIdxB), .rdWidthB(rdWidthB), .rdDataB(rdDataB)
  );
endmodule

// File: tb/alias_vrf_tb.sv
module alias_vrf_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0;
  logic [4:0] wrIdx = '0;
  logic [1:0] wrWidth = 2'b11;
  logic [255:0] wrData = '0;
  logic [4:0] rdIdxA = '0, rdIdxB = '0;
  logic [1:0] rdWidthA = 2'b10, rdWidthB = 2'b10;
  logic [255:0] rdDataA, rdDataB;

  logic s_wrEn = 1'b0;
  logic [4:0] s_wrIdx = '0, s_rdIdx = '0;
  logic [1:0] s_wrWidth = 2'b11, s_rdWidth = 2'b10;
  logic [255:0] s_wrData = '0;
  logic [255:0] s_rdData, s_unused;

  int checks = 0;
  int errors = 0;
  logic [255:0] model [32];

  always #5 clk = ~clk;

  alias_vrf u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrIdx(wrIdx), .wrWidth(wrWidth), .wrData(wrData),
    .rdIdxA(rdIdxA), .rdWidthA(rdWidthA), .rdDataA(rdDataA),
    .rdIdxB(rdIdxB), .rdWidthB(rdWidthB), .rdDataB(rdDataB)
  );

  alias_vrf #(.LONG_EN(1'b0)) u_dut128 (
    .clk(clk), .rstN(rstN), .wrEn(s_wrEn), .wrIdx(s_wrIdx), .wrWidth(s_wrWidth), .wrData(s_wrData),
    .rdIdxA(s_rdIdx), .rdWidthA(s_rdWidth), .rdDataA(s_rdData),
    .rdIdxB(5'd0), .rdWidthB(2'b11), .rdDataB(s_unused)
  );

  // vector: idx[16:12] wrWidth[11:10] rdWidth[9:8] seed[7:0]
  localparam logic [16:0] VECS [0:11] = '{
    {5'd3,  2'b10, 2'b10, 8'h11},  // R2 full write
    {5'd3,  2'b00, 2'b10, 8'h22},  // R4 R5 scalar merge
    {5'd3,  2'b01, 2'b10, 8'h33},  // R3 R5 short merge
    {5'd3,  2'b00, 2'b00, 8'h44},  // R4 scalar view
    {5'd3,  2'b01, 2'b01, 8'h55},  // R3 short view
    {5'd0,  2'b10, 2'b00, 8'h66},  // R1 index 0
    {5'd31, 2'b10, 2'b01, 8'h77},  // R1 index 31
    {5'd31, 2'b11, 2'b10, 8'h88},  // R6 no-write tag
    {5'd31, 2'b00, 2'b11, 8'h99},  // R9 read tag 11
    {5'd17, 2'b01, 2'b10, 8'hAA},
    {5'd17, 2'b10, 2'b10, 8'hBB},
    {5'd17, 2'b11, 2'b10, 8'hCC}
  };

  function automatic logic [255:0] mkData(input logic [7:0] seed);
    logic [255:0] d;
    for (int k = 0; k < 8; k++) d[k*32 +: 32] = {seed, seed ^ 8'(k), 8'(k), ~seed};
    return d;
  endfunction

  function automatic logic [255:0] view(input logic [255:0] e, input logic [1:0] w);
    case (w)
      2'b00: return {192'd0, e[63:0]};
      2'b01: return {128'd0, e[127:0]};
      2'b10: return e;
      default: return '0;
    endcase
  endfunction

  task automatic modelWrite(input logic [4:0] i, input logic [1:0] w, input logic [255:0] d);
    case (w)
      2'b00: model[i][63:0]  = d[63:0];
      2'b01: model[i][127:0] = d[127:0];
      2'b10: model[i]        = d;
      default: ;
    endcase
  endtask

  task automatic chk(input string req, input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 32; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    // R8 reset state of every entry
    for (int i = 0; i < 32; i++) begin
      rdIdxA = 5'(i);
      #1 chk("R8 reset clear", rdDataA, '0);
      @(negedge clk);
    end
    rstN = 1'b1;

    // table walk
    for (int v = 0; v < 12; v++) begin
      logic [4:0] idx;
      logic [1:0] ww, rw;
      logic [255:0] d;
      idx = VECS[v][16:12];
      ww  = VECS[v][11:10];
      rw  = VECS[v][9:8];
      d   = mkData(VECS[v][7:0]);
      @(negedge clk);
      wrEn = 1'b1; wrIdx = idx; wrWidth = ww; wrData = d;
      rdIdxA = idx; rdWidthA = rw;
      rdIdxB = idx ^ 5'd1; rdWidthB = 2'b10;
      #1;
      chk("R7 same-cycle old value", rdDataA, view(model[idx], rw));
      chk("R10 port B independent", rdDataB, view(model[idx ^ 5'd1], 2'b10));
      @(posedge clk);
      #1;
      wrEn = 1'b0;
      modelWrite(idx, ww, d);
      #1;
      chk("R1 R5 R6 R9 view after write", rdDataA, view(model[idx], rw));
      rdWidthB = 2'b10; rdIdxB = idx;
      #1 chk("R2 R5 long view of entry", rdDataB, model[idx]);
    end

    // R6 write enable low changes nothing
    @(negedge clk);
    wrEn = 1'b0; wrIdx = 5'd3; wrWidth = 2'b10; wrData = '1;
    @(negedge clk);
    rdIdxA = 5'd3; rdWidthA = 2'b10;
    #1 chk("R6 enable low", rdDataA, model[3]);

    // R11 reduced build: long write keeps only 128 bits
    @(negedge clk);
    s_wrEn = 1'b1; s_wrIdx = 5'd5; s_wrWidth = 2'b10; s_wrData = mkData(8'hDE);
    s_rdIdx = 5'd5; s_rdWidth = 2'b10;
    @(posedge clk);
    #1 s_wrEn = 1'b0;
    #1 chk("R11 reduced long read", s_rdData, {128'd0, mkData(8'hDE)} & {128'd0, {128{1'b1}}});
    s_wrWidth = 2'b00; s_wrData = mkData(8'h12); s_wrEn = 1'b1;
    @(posedge clk);
    #1 s_wrEn = 1'b0;
    #1 chk("R11 reduced scalar merge", s_rdData,
           {128'd0, mkData(8'hDE)[127:64], mkData(8'h12)[63:0]});

    // R8 reset mid-run clears written entries
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    rdIdxA = 5'd17; rdWidthA = 2'b10; rdIdxB = 5'd31; rdWidthB = 2'b10;
    #1;
    chk("R8 reset clears entry 17", rdDataA, '0);
    chk("R8 reset clears entry 31", rdDataB, '0);
    rstN = 1'b1;

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule